// File: doc/BRIEF.md
# I/O Rail Deep Power-Down Sequencer

This block moves groups of I/O rails into and out of deep power-down on request from software. Rails are split across request banks of one 32-bit word each. Rail `r` lives in bank `r / 32` at bit `r % 32`. The two top bits of every request word hold a command rather than rail selects, so each bank can address only its low 30 rails.

Before it issues a request, software sets the sampling gate and programs a settle count in clock cycles. The count must span at least 200 ns, which is `ceil(200 / clock period in ns)`. Software then writes a command and a rail mask to one request register. The block raises `busy` and counts the settle window down. When the window closes it updates the selected status bits in one step and returns the command field to idle. Software clears the sampling gate once `busy` is low.

Register word addresses:

| Address | Register |
|---|---|
| 0 | Gate, bit 0 |
| 1 | Settle count, 16 bits |
| 2 | Bank 0 request |
| 3 | Bank 0 status |
| 4 | Bank 1 request |
| 5 | Bank 1 status |
| 6 | Busy, bit 0, read-only |

Top module: `rdpd_ctrl`

## Requirements
- R1: After reset every register reads 0 and `busy` is 0.
- R2: The gate register returns bit 0 as written and the settle register returns bits 15:0 as written. Neither write disturbs rail status.
- R3: Command code 2 (bits 31:30 = `10`) sets the selected status bits, meaning those rails are powered down. Code 1 (`01`) clears them, meaning those rails are powered. Status bits that are not selected keep their value.
- R4: Take a request write that is accepted at clock edge E with settle count N. `busy` reads 1 from E until edge E+N+1. At that edge the status bits change and `busy` returns to 0. Status does not change before that edge.
- R5: When the request completes, bits 31:30 of that request register read 0 and bits 29:0 keep the written select mask.
- R6: A request written while the gate bit is 0 starts no countdown and leaves status unchanged. The word is still stored in the request register.
- R7: A write to any request register while `busy` is 1 is discarded. The stored select bits and the status stay unchanged.
- R8: Command codes 0 and 3 start no countdown and change no status.
- R9: Status bits 31:30 always read 0, so rails whose number modulo 32 is 30 or 31 cannot be selected. The highest selectable rail in bank 1 is rail 61, at bit 29.
- R10: A request affects only the status of the bank that it was written to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| busy | output | 1 | Settle countdown in progress |

## Verification
The main path runs in two ways. Randomised requests mix bank, command code, mask, gate state and a settle count of 0 to 7. Directed cases cover a zero settle count, a long window with writes landing on both banks mid-count, and rail 61 against the dead bits 30 and 31.

The random mix separates set from clear on overlapping masks, and real commands from codes 0 and 3. Every accepted request has its busy length counted against N+1. Status is also read at the start of the window, which exposes an early update.

The directed cases show that a dropped write leaves the select bits intact, and that the other bank is unaffected.

// File: rtl/rdpd_pkg.sv
package rdpd_pkg;

    localparam int WORD_W = 32;
    localparam int SEL_W  = 30;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_RELEASE = 2'd1,
        CMD_ENTER   = 2'd2,
        CMD_RSVD    = 2'd3
    } rail_cmd_e;

    typedef struct packed {
        rail_cmd_e          cmd;
        logic [SEL_W-1:0]   sel;
    } req_word_t;

    localparam int ADDR_GATE      = 0;
    localparam int ADDR_SETTLE    = 1;
    localparam int ADDR_BANK_BASE = 2;

    function automatic logic is_action(rail_cmd_e c);
        return (c == CMD_RELEASE) || (c == CMD_ENTER);
    endfunction

    function automatic logic [SEL_W-1:0] next_status(logic [SEL_W-1:0] cur,
                                                     req_word_t r);
        logic [SEL_W-1:0] nxt;
        case (r.cmd)
            CMD_ENTER:   nxt = cur | r.sel;
            CMD_RELEASE: nxt = cur & ~r.sel;
            default:     nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rdpd_timer.sv
module rdpd_timer #(
    parameter int CNT_W = 16,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] settle,
    input  logic [IDX_W-1:0] bank_in,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] bank_q
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt_q  <= '0;
            bank_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) busy  <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (start) begin
            busy   <= 1'b1;
            cnt_q  <= settle;
            bank_q <= bank_in;
        end
    end

    assign done = busy && (cnt_q == '0);

    // Window stays open until the count is exhausted
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> busy);

    // The window closes right after the terminal cycle
    p_finish_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // The owning bank is frozen for the whole window
    p_owner_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(bank_q));

endmodule

// File: rtl/rdpd_bank.sv
module rdpd_bank
    import rdpd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  req_word_t         wword,
    input  logic              apply,
    output req_word_t         req_q,
    output logic [SEL_W-1:0]  stat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            stat_q <= '0;
        end else if (apply) begin
            stat_q    <= next_status(stat_q, req_q);
            req_q.cmd <= CMD_IDLE;
        end else if (store) begin
            req_q <= wword;
        end
    end

    // Status moves only on the terminal cycle of a window
    p_stat_apply_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat_q) |-> $past(apply));

    // Command field is back to idle after completion
    p_cmd_idle_r5: assert property (@(posedge clk) disable iff (rst)
        apply |=> (req_q.cmd == CMD_IDLE));

    // Select mask survives completion
    p_sel_keep_r5: assert property (@(posedge clk) disable iff (rst)
        apply |=> $stable(req_q.sel));

endmodule

// File: rtl/rdpd_ctrl.sv
module rdpd_ctrl
    import rdpd_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int CNT_W     = 16,
    parameter int ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic               busy
);

    localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int ADDR_BUSY = ADDR_BANK_BASE + 2 * NUM_BANKS;

    logic               gate_q;
    logic [CNT_W-1:0]   settle_q;
    logic [NUM_BANKS-1:0] req_hit, store_vec, apply_vec;
    req_word_t          req_arr  [NUM_BANKS];
    logic [SEL_W-1:0]   stat_arr [NUM_BANKS];
    req_word_t          wword;
    logic               start, done;
    logic [IDX_W-1:0]   bank_in, bank_q;

    assign wword = req_word_t'(reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q   <= 1'b0;
            settle_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(ADDR_GATE))   gate_q   <= reg_wdata[0];
            if (reg_addr == ADDR_W'(ADDR_SETTLE)) settle_q <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bank_in = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            req_hit[b] = reg_wr && (reg_addr == ADDR_W'(ADDR_BANK_BASE + 2 * b));
            if (req_hit[b]) bank_in = IDX_W'(b);
        end
    end

    assign store_vec = busy ? '0 : req_hit;
    assign start     = (|store_vec) && gate_q && is_action(wword.cmd);

    rdpd_timer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .settle  (settle_q),
        .bank_in (bank_in),
        .busy    (busy),
        .done    (done),
        .bank_q  (bank_q)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        assign apply_vec[g] = done && (bank_q == IDX_W'(g));

        rdpd_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .store  (store_vec[g]),
            .wword  (wword),
            .apply  (apply_vec[g]),
            .req_q  (req_arr[g]),
            .stat_q (stat_arr[g])
        );

        // Writes landing inside a window are discarded
        p_drop_busy_r7: assert property (@(posedge clk) disable iff (rst)
            (busy && req_hit[g]) |=> $stable(req_arr[g].sel));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_GATE))   reg_rdata[0] = gate_q;
        if (reg_addr == ADDR_W'(ADDR_SETTLE)) reg_rdata[CNT_W-1:0] = settle_q;
        if (reg_addr == ADDR_W'(ADDR_BUSY))   reg_rdata[0] = busy;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(ADDR_BANK_BASE + 2 * b))
                reg_rdata = WORD_W'(req_arr[b]);
            if (reg_addr == ADDR_W'(ADDR_BANK_BASE + 2 * b + 1))
                reg_rdata = {2'b00, stat_arr[b]};
        end
    end

    // A closed gate never opens a window
    p_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (!gate_q && !busy) |=> !busy);

    // Only one bank is updated at a time
    p_one_bank_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(apply_vec));

    // The read-only flag agrees with the window
    p_busy_read_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_W'(ADDR_BUSY)) |-> (reg_rdata[0] == busy));

endmodule

// File: tb/tb_rdpd_ctrl.sv
module tb_rdpd_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_req  [2];
    logic [29:0] m_stat [2];

    always #4 clk = ~clk;

    rdpd_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy)
    );

    function automatic logic [29:0] exp_stat(logic [29:0] cur, logic [1:0] cmd,
                                             logic [29:0] sel);
        if (cmd == 2'd2) return cur | sel;
        if (cmd == 2'd1) return cur & ~sel;
        return cur;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        for (int b = 0; b < 2; b++) begin
            rd(4'(2 + 2 * b), v);
            check(v == m_req[b], {tag, " req R5"}, v, m_req[b]);
            rd(4'(3 + 2 * b), v);
            check(v == {2'b00, m_stat[b]}, {tag, " status R3 R9 R10"}, v, {2'b00, m_stat[b]});
        end
    endtask

    task automatic request(input int bank, input logic [1:0] cmd,
                           input logic [29:0] sel, input logic gate,
                           input logic [15:0] settle);
        logic [31:0] v;
        int n;
        wr(4'd0, {31'd0, gate});
        wr(4'd1, {16'd0, settle});
        wr(4'(2 + 2 * bank), {cmd, sel});
        if (gate && (cmd == 2'd1 || cmd == 2'd2)) begin
            n = 0;
            rd(4'(3 + 2 * bank), v);
            check(v[29:0] == m_stat[bank], "R4 status held in window", v, {2'b00, m_stat[bank]});
            while (busy && n < 70000) begin
                n++;
                @(negedge clk);
            end
            check(n == int'(settle) + 1, "R4 busy length", n, int'(settle) + 1);
            m_stat[bank] = exp_stat(m_stat[bank], cmd, sel);
            m_req[bank]  = {2'b00, sel};
        end else begin
            check(busy == 1'b0, (gate ? "R8 no window" : "R6 no window"), busy, 0);
            m_req[bank] = {cmd, sel};
        end
        check_all("after request");
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = 32'd1234;
        v = $urandom(seed);
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int b = 0; b < 2; b++) begin m_req[b] = '0; m_stat[b] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int a = 0; a < 7; a++) begin
            rd(4'(a), v);
            check(v == 32'd0, "R1 reset value", v, 0);
        end
        check(busy == 1'b0, "R1 busy at reset", busy, 0);

        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); check(v == 32'd1, "R2 gate readback", v, 1);
        wr(4'd1, 32'hABCD_1234);
        rd(4'd1, v); check(v == 32'h0000_1234, "R2 settle readback", v, 32'h1234);
        check_all("R2 no side effect");

        request(0, 2'd2, 30'h0000_00F0, 1'b1, 16'd3);
        request(0, 2'd1, 30'h0000_0030, 1'b1, 16'd0);
        request(1, 2'd2, 30'h2000_0000, 1'b1, 16'd2);
        request(0, 2'd2, 30'h3FFF_FFFF, 1'b0, 16'd1);
        request(0, 2'd3, 30'h3FFF_FFFF, 1'b1, 16'd1);
        request(1, 2'd0, 30'h1FFF_FFFF, 1'b1, 16'd1);

        wr(4'd1, 32'd20);
        wr(4'd2, {2'd2, 30'h0000_0001});
        wr(4'd4, {2'd1, 30'h3FFF_FFFF});
        wr(4'd2, {2'd2, 30'h0000_FF00});
        while (busy) @(negedge clk);
        m_stat[0] = m_stat[0] | 30'h1;
        m_req[0]  = {2'b00, 30'h1};
        check_all("R7 dropped writes");

        for (int i = 0; i < 40; i++) begin
            request(int'($urandom % 2), 2'($urandom), 30'($urandom),
                    ($urandom % 5) != 0, 16'($urandom % 8));
        end

        wr(4'd4, {2'd2, 30'h3FFF_FFFF});
        while (busy) @(negedge clk);
        rd(4'd5, v);
        check(v[31:30] == 2'b00, "R9 dead bits", v, {2'b00, v[29:0]});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule